// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host reach an asynchronous static memory of 16K one-bit words that has separate data-in and data-out pins, an active-low chip select and an active-low write enable. The host offers one request at a time over a valid/ready handshake: a 14-bit address, a write flag and one write bit. The controller captures the request and then drives the memory pins through a fixed sequence of phases. Each phase lasts a parameterised number of clock cycles.

A write first holds chip select low with write enable high for an address-setup phase. It then pulls write enable low for a strobe phase. The strobe is the longer of the write-pulse and data-setup counts. Write enable and chip select then rise together. A read holds chip select low with write enable high for the setup phase plus an access phase. The data-out pin is sampled on the last cycle of that window, and the sampled bit is returned with a one-cycle strobe.

Every access ends with a recovery phase in which chip select is high. Chip select also stays high whenever the controller is idle, which keeps the memory in standby. Address and data-in change only at acceptance, and acceptance happens only while chip select is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, mem_cs_n and mem_we_n are 1, req_ready is 1, and rd_valid and wr_done are 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access is over. Address, write flag and write bit are captured at that edge, so later changes on the request inputs have no effect on the access.
- R3: mem_we_n is 0 only while mem_cs_n is 0. It is never 0 during a read access.
- R4: mem_addr and mem_din stay constant in every cycle that mem_cs_n stays 0. This includes the whole time mem_we_n is 0.
- R5: In a write, mem_cs_n is 0 with mem_we_n 1 for exactly ASU_CYC cycles. Then mem_we_n is 0 for exactly max(WP_CYC, DSU_CYC) cycles. After that both pins rise in the same cycle.
- R6: At the end of a write, the memory holds the captured write bit at the captured address. wr_done is 1 for exactly one cycle per write: the first cycle after mem_we_n returns to 1.
- R7: In a read, mem_cs_n is 0 with mem_we_n 1 for ASU_CYC + ACC_CYC cycles. The data-out pin is sampled on the last of those cycles. rd_valid is then 1 for exactly one cycle, with rd_data equal to the bit stored at the captured address.
- R8: A write never raises rd_valid and leaves rd_data unchanged.
- R9: After every access, mem_cs_n is 1 for REC_CYC cycles before req_ready returns. While idle, mem_cs_n is 1.
- R10: req_ready is 0 for exactly ASU_CYC + max(WP_CYC, DSU_CYC) + REC_CYC cycles for a write, and ASU_CYC + ACC_CYC + REC_CYC cycles for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address of the request |
| req_wdata | input | 1 | Bit to store on a write |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds a fresh read result |
| rd_data | output | 1 | Last bit read from the memory |
| wr_done | output | 1 | One-cycle strobe: a write has finished |
| mem_addr | output | 14 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_din | output | 1 | Memory data-in pin |
| mem_dout | input | 1 | Memory data-out pin |

## Verification
The address sweep covers 256 locations spread across the whole 14-bit range, including addresses 0 and 16383. Each location is written with a bit that depends on its address, read back, then written with the inverse and read again. The read-back catches address or data capture errors, and it also catches a bit dropped or sampled before the access window closes. The inverted pass catches a memory that ignores writes or a read path stuck at one value. For every transaction the bench counts the cycles of busy time, chip-select-low time and write-enable-low time, and compares them against values computed from the phase parameters. This separates a wrong phase length from a wrong phase order. The behavioural memory also reports an address that moves during a strobe and a strobe that ends before the data-setup count.

// File: rtl/sramc_pkg.sv
// Shared types for the asynchronous SRAM access controller.
package sramc_pkg;

    // Phases of one memory access, in the order a transaction visits them.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_STROBE  = 3'd2,
        PH_ACCESS  = 3'd3,
        PH_RECOVER = 3'd4
    } phase_e;

endpackage

// File: rtl/sramc_phase_timer.sv
// Down-counter that times one phase.
// Assumes: load is pulsed at phase entry with (length - 1).
// done is high on the last cycle of the phase.
module sramc_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Reload at phase entry, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sramc_seq.sv
// Phase sequencer: steps IDLE -> SETUP -> (STROBE | ACCESS) -> RECOVER -> IDLE.
// Assumes: all phase lengths are at least one cycle, and op_write is stable
// from the cycle after start until the access returns to IDLE.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int ASU_CYC = 1,
    parameter int STB_CYC = 2,
    parameter int ACC_CYC = 2,
    parameter int REC_CYC = 1,
    parameter int CNT_W   = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   op_write,
    output phase_e phase,
    output logic   sample_now,
    output logic   write_end
);
    localparam logic [CNT_W-1:0] LD_ASU = CNT_W'(ASU_CYC - 1);
    localparam logic [CNT_W-1:0] LD_STB = CNT_W'(STB_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);

    phase_e           ph_q, ph_d;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // Next phase and timer reload for the phase being entered.
    always_comb begin
        ph_d       = ph_q;
        t_load     = 1'b0;
        t_val      = '0;
        sample_now = 1'b0;
        write_end  = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (start) begin
                ph_d = PH_SETUP; t_load = 1'b1; t_val = LD_ASU;
            end
            PH_SETUP: if (t_done) begin
                t_load = 1'b1;
                if (op_write) begin ph_d = PH_STROBE; t_val = LD_STB; end
                else          begin ph_d = PH_ACCESS; t_val = LD_ACC; end
            end
            PH_STROBE: if (t_done) begin
                ph_d = PH_RECOVER; t_load = 1'b1; t_val = LD_REC; write_end = 1'b1;
            end
            PH_ACCESS: if (t_done) begin
                ph_d = PH_RECOVER; t_load = 1'b1; t_val = LD_REC; sample_now = 1'b1;
            end
            PH_RECOVER: if (t_done) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;
endmodule

// File: rtl/sram_async_ctrl.sv
// Asynchronous SRAM access controller top.
// Captures one host request, then drives the memory pins from the phase
// sequencer. Address and data-in change only at acceptance, which happens
// only while chip select is high. Write enable is low only in the strobe phase.
// Assumes: every *_CYC parameter is >= 1 and covers the memory's timing at the
// clock period in use.
module sram_async_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int ASU_CYC = 1,
    parameter int WP_CYC  = 2,
    parameter int DSU_CYC = 1,
    parameter int ACC_CYC = 2,
    parameter int REC_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rd_valid,
    output logic              rd_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);
    localparam int STB_CYC = (WP_CYC > DSU_CYC) ? WP_CYC : DSU_CYC;
    localparam int MAX_A   = (ASU_CYC > STB_CYC) ? ASU_CYC : STB_CYC;
    localparam int MAX_B   = (ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    phase_e            phase;
    logic              accept, sample_now, write_end;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q, wd_q, rd_q, rv_q, wdn_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sramc_seq #(
        .ASU_CYC (ASU_CYC),
        .STB_CYC (STB_CYC),
        .ACC_CYC (ACC_CYC),
        .REC_CYC (REC_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .op_write   (wr_q),
        .phase      (phase),
        .sample_now (sample_now),
        .write_end  (write_end)
    );

    // Capture the request fields at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
            wd_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
        end
    end

    // Sample data-out at the end of a read window and raise the done strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            rv_q  <= 1'b0;
            wdn_q <= 1'b0;
        end else begin
            rv_q  <= sample_now;
            wdn_q <= write_end;
            if (sample_now) rd_q <= mem_dout;
        end
    end

    // Pin decode from the phase register.
    always_comb begin
        mem_cs_n = !(phase == PH_SETUP || phase == PH_STROBE || phase == PH_ACCESS);
        mem_we_n = (phase != PH_STROBE);
    end

    assign mem_addr = addr_q;
    assign mem_din  = wd_q;
    assign rd_valid = rv_q;
    assign rd_data  = rd_q;
    assign wr_done  = wdn_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Protocol checker for sram_async_ctrl, attached by bind.
// Watches only the top-level ports. Run lengths of chip select and write
// enable are measured with counters, not with long $past windows.
module sram_async_ctrl_chk #(
    parameter int ADDR_W  = 14,
    parameter int ASU_CYC = 1,
    parameter int STB_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              wr_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_din
);
    logic [7:0] we_run, cs_run;

    // Count consecutive low cycles of write enable and chip select (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            cs_run <= '0;
        end else begin
            we_run <= !mem_we_n ? ((we_run == 8'hFF) ? we_run : we_run + 1'b1) : 8'd0;
            cs_run <= !mem_cs_n ? ((cs_run == 8'hFF) ? cs_run : cs_run + 1'b1) : 8'd0;
        end
    end

    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R4
    AST_DIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_din)); // R4
    AST_SETUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(mem_we_n)) |-> (cs_run == 8'(ASU_CYC))); // R5
    AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !$past(mem_we_n)) |-> (we_run == 8'(STB_CYC) && mem_cs_n)); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !rd_valid); // R8
    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n); // R9
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .ASU_CYC (ASU_CYC),
    .STB_CYC (STB_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_din   (mem_din)
);

// File: tb/sim_sram_async_ctrl.sv
// Bench: address sweep with two data patterns against a behavioural memory.
module sim_sram_async_ctrl;
    localparam int AW  = 14;
    localparam int ASU = 2;
    localparam int WP  = 2;
    localparam int DSU = 3;
    localparam int ACC = 3;
    localparam int REC = 1;
    localparam int STB = (WP > DSU) ? WP : DSU;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rd_valid, rd_data, wr_done;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_din, mem_dout;

    int n_chk = 0, n_fail = 0, model_err = 0, cyc = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .ASU_CYC(ASU), .WP_CYC(WP), .DSU_CYC(DSU),
        .ACC_CYC(ACC), .REC_CYC(REC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_din(mem_din), .mem_dout(mem_dout)
    );

    // Behavioural memory: reads while selected with write enable high.
    logic [16383:0] mem = '0;
    logic           p_we_n = 1'b1, p_din = 1'b0;
    logic [AW-1:0]  p_addr = '0;
    int             din_run = 0;

    assign mem_dout = (!mem_cs_n && mem_we_n) ? mem[mem_addr] : 1'b0;

    // Store at the end of the strobe, and flag address moves or short data setup.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && !p_we_n && mem_addr != p_addr) model_err++;
            if (!mem_we_n) din_run = (!p_we_n && mem_din == p_din) ? din_run + 1 : 1;
            if (mem_we_n && !p_we_n) begin
                if (din_run < DSU) model_err++;
                mem[p_addr] = p_din;
            end
        end
        p_we_n = mem_we_n;
        p_addr = mem_addr;
        p_din  = mem_din;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // One transaction; caller starts at a negedge with req_ready high.
    task automatic txn(input logic wr, input logic [AW-1:0] a, input logic d,
                       output logic rd);
        int busy = 0, cs_lo = 0, we_lo = 0, rv = 0, wd = 0;
        logic rd_before;
        rd = 1'b0;
        rd_before = rd_data;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        // R2: change every request input after acceptance
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
        chk(req_ready == 1'b0, "R2 ready drops after accept", int'(req_ready), 0);
        while (!req_ready && busy < 100) begin
            busy++;
            if (!mem_cs_n) cs_lo++;
            if (!mem_we_n) we_lo++;
            if (rd_valid) begin rv++; rd = rd_data; end
            if (wr_done) wd++;
            @(negedge clk);
        end
        if (wr) begin
            chk(busy == ASU + STB + REC, "R10 write busy cycles", busy, ASU + STB + REC);
            chk(cs_lo == ASU + STB, "R5 write cs low cycles", cs_lo, ASU + STB);
            chk(we_lo == STB, "R5 write strobe cycles", we_lo, STB);
            chk(wd == 1, "R6 wr_done pulses", wd, 1);
            chk(rv == 0 && rd_data == rd_before, "R8 write leaves read side", rv, 0);
        end else begin
            chk(busy == ASU + ACC + REC, "R10 read busy cycles", busy, ASU + ACC + REC);
            chk(cs_lo == ASU + ACC, "R7 read cs low cycles", cs_lo, ASU + ACC);
            chk(we_lo == 0, "R3 no strobe on read", we_lo, 0);
            chk(rv == 1 && wd == 0, "R7 rd_valid pulses", rv, 1);
        end
        chk(mem_cs_n == 1'b1, "R9 standby when idle", int'(mem_cs_n), 1);
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        return AW'(i * 64 + (i % 64));
    endfunction

    initial begin
        logic r;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && req_ready && !rd_valid && !wr_done,
            "R1 reset values", int'({mem_cs_n, mem_we_n, req_ready}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && req_ready && !rd_valid && !wr_done,
            "R1 after release", int'({mem_cs_n, mem_we_n, req_ready}), 7);
        repeat (4) begin
            @(negedge clk);
            chk(mem_cs_n == 1'b1, "R9 idle standby", int'(mem_cs_n), 1);
        end
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 256; i++) begin
                logic [AW-1:0] a;
                a = addr_of(i);
                txn(1'b1, a, (^a) ^ pass[0], r);
                // R6: the stored bit is visible at the memory
                chk(mem[a] == ((^a) ^ pass[0]), "R6 stored bit", int'(mem[a]),
                    int'((^a) ^ pass[0]));
            end
            for (int i = 0; i < 256; i++) begin
                logic [AW-1:0] a;
                a = addr_of(i);
                txn(1'b0, a, 1'b0, r);
                chk(r == ((^a) ^ pass[0]), "R7 read data", int'(r), int'((^a) ^ pass[0]));
            end
        end
        chk(model_err == 0, "R4 R5 memory model timing errors", model_err, 0);
        finish_run();
    end
endmodule